// File: doc/BRIEF.md
# Serial Bus Block Read Slave

This block is a slave on a two-wire serial bus that serves two transactions on a register space. The first is a single-byte write that presets an internal address pointer. The second is a block read. In the block read, the master writes command C1h, issues a repeated START and then reads a byte count followed by data bytes. The data bytes come from a memory behind a synchronous read port. SCL and SDA are taken in through a two-flop synchroniser. The block only ever pulls SDA low, through an open-drain enable.

The pointer resets to an address that is not allowed, so a block read is refused until a pointer preset has succeeded. Legal addresses form two windows: 00h–2Fh, and 40h–9Fh. In the upper window the pointer steps straight across 7Fh→80h. The pointer never moves past 2Fh or 9Fh.

The memory side has no back-pressure and no ready signal. A one-cycle `mem_rd_en` pulse asks for the byte at `mem_rd_addr`. The memory must present it on `mem_rd_data` in the next cycle.

Top module: `smb_blkrd_slave`

## Requirements
- R1: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. A STOP returns the block to idle, releases SDA and cancels any pending block read.
- R2: The 7-bit address is compared with parameter SLV_ADDR; the address byte carries the address in bits 7:1 and the read flag in bit 0. On a mismatch the block does not acknowledge and ignores all traffic until the next START or STOP.
- R3: After address+write, any byte other than C1h is a pointer preset. It is acknowledged and loaded only if the block is not busy and the value is in 00h–2Fh or 40h–9Fh. Otherwise it is NACKed and the pointer keeps its value.
- R4: Command C1h is acknowledged only if `busy_i` is low and the pointer holds a legal address. Otherwise it is NACKed and the pointer is unchanged. The pointer resets to FFh, which is illegal.
- R5: After a repeated START, address+read is acknowledged if an acknowledged C1h came just before. The first byte the slave sends is then the count 10h (16).
- R6: After the count, the slave sends data bytes MSB first, each read from memory at the pointer. It sends at most 16. If the master acknowledges the 16th byte, SDA stays released.
- R7: The pointer advances by one after each data byte is fully sent. It stays at 2Fh and at 9Fh, and steps from 7Fh to 80h.
- R8: A master NACK, or a STOP, ends the data phase and leaves SDA released.
- R9: Address+read that does not follow an acknowledged C1h is NACKed.
- R10: The slave changes SDA only while SCL is low. Each data byte is fetched from memory before the SCL falling edge that starts its first bit.
- R11: After reset SDA is released and no memory read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy_i | input | 1 | Device busy: command and preset bytes are NACKed |
| mem_rd_en | output | 1 | One-cycle read request |
| mem_rd_addr | output | AW | Read address (the current pointer) |
| mem_rd_data | input | 8 | Read data, valid the cycle after the request |

## Verification
The bench aims at the pointer edges. One read runs into 2Fh and must repeat that byte for the rest of the block; a design that wrapped or kept counting would return bytes from outside the window. A second read crosses 7Fh→80h, and a design that stopped or wrapped at the window top would repeat 7Fh. Rejected presets, busy refusals, address mismatches and early termination are each followed by a fresh read that reveals the pointer. A design that loaded on NACK, or advanced on a partly sent byte, therefore starts that read at the wrong address. Reading a 17th byte after the 16th is acknowledged must give FFh; a design that kept driving would return stale or memory data there.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK, ST_TX, ST_TX_ACK, ST_SKIP
  } smb_st_e;

  localparam logic [7:0] CMD_BLKRD = 8'hC1;
endpackage

// File: rtl/smb_pin_sync.sv
module smb_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_p    <= scl_pipe[STAGES-1];
      sda_p    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smb_ptr.sv
module smb_ptr #(
  parameter int          AW     = 8,
  parameter logic [AW-1:0] RST_V = 8'hFF,
  parameter logic [AW-1:0] A_HI  = 8'h2F,
  parameter logic [AW-1:0] B_LO  = 8'h40,
  parameter logic [AW-1:0] B_HI  = 8'h9F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          inc,
  output logic [AW-1:0] ptr,
  output logic          ptr_ok,
  output logic          cand_ok
);
  function automatic logic in_win(input logic [AW-1:0] a);
    return (a <= A_HI) || (a >= B_LO && a <= B_HI);
  endfunction

  assign ptr_ok  = in_win(ptr);
  assign cand_ok = in_win(ld_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               ptr <= RST_V;
    else if (ld)                              ptr <= ld_val;
    else if (inc && ptr != A_HI && ptr != B_HI) ptr <= ptr + 1'b1;
  end

  // R7
  win_top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && (ptr == A_HI || ptr == B_HI)) |=> $stable(ptr));
  // R3
  ptr_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !inc) |=> $stable(ptr));
endmodule

// File: rtl/smb_blkrd_slave.sv
module smb_blkrd_slave
  import smb_pkg::*;
#(
  parameter int         AW       = 8,
  parameter logic [6:0] SLV_ADDR = 7'h52,
  parameter int         BYTES    = 16,
  parameter int         SYNC_STG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          busy_i,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [7:0]    mem_rd_data
);
  localparam int IW = $clog2(BYTES + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  smb_st_e st;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [IW-1:0] byte_idx;
  logic oe_q, rw_q, armed, mack, rd_pend, rd_vld;
  logic [AW-1:0] ptr;
  logic ptr_ok, cand_ok, ptr_ld, ptr_inc, is_c1, cmd_ok, cmd_dec;

  smb_pin_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign is_c1   = (shreg == CMD_BLKRD);
  assign cmd_ok  = !busy_i && (is_c1 ? ptr_ok : cand_ok);
  assign cmd_dec = (st == ST_CMD) && scl_fall && (bitcnt == 4'd8) && !start_det && !stop_det;
  assign ptr_ld  = cmd_dec && !is_c1 && cmd_ok;
  assign ptr_inc = (st == ST_TX_ACK) && scl_rise && (byte_idx != '0) && !stop_det && !start_det;

  smb_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ld(ptr_ld), .ld_val(shreg[AW-1:0]), .inc(ptr_inc),
    .ptr(ptr), .ptr_ok(ptr_ok), .cand_ok(cand_ok)
  );

  assign sda_oe      = oe_q;
  assign mem_rd_en   = rd_pend;
  assign mem_rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bitcnt <= '0; shreg <= '0; byte_idx <= '0;
      oe_q <= 1'b0; rw_q <= 1'b0; armed <= 1'b0; mack <= 1'b0;
      rd_pend <= 1'b0; rd_vld <= 1'b0;
    end else begin
      rd_pend <= 1'b0;
      rd_vld  <= rd_pend;
      if (rd_vld) shreg <= mem_rd_data;
      if (stop_det) begin
        st <= ST_IDLE; oe_q <= 1'b0; armed <= 1'b0;
      end else if (start_det) begin
        st <= ST_ADDR; oe_q <= 1'b0; bitcnt <= '0;
      end else begin
        case (st)
          ST_ADDR, ST_CMD: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (st == ST_ADDR) begin
                if (shreg[7:1] != SLV_ADDR) st <= ST_SKIP;
                else if (!shreg[0]) begin
                  oe_q <= 1'b1; st <= ST_ADDR_ACK; rw_q <= 1'b0; armed <= 1'b0;
                end else if (armed) begin
                  oe_q <= 1'b1; st <= ST_ADDR_ACK; rw_q <= 1'b1; armed <= 1'b0;
                  shreg <= 8'(BYTES); byte_idx <= '0;
                end else st <= ST_SKIP;
              end else if (cmd_ok) begin
                oe_q <= 1'b1; st <= ST_CMD_ACK; armed <= is_c1;
              end else st <= ST_SKIP;
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            bitcnt <= '0;
            if (rw_q) begin st <= ST_TX; oe_q <= ~shreg[7]; end
            else begin st <= ST_CMD; oe_q <= 1'b0; end
          end
          ST_CMD_ACK: if (scl_fall) begin
            oe_q <= 1'b0; st <= ST_SKIP;
          end
          ST_TX: if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              oe_q <= 1'b0; st <= ST_TX_ACK;
            end else begin
              oe_q   <= ~shreg[6];
              shreg  <= {shreg[6:0], 1'b1};
              bitcnt <= bitcnt + 1'b1;
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mack    <= ~sda_s;
              rd_pend <= ~sda_s && (byte_idx < IW'(BYTES));
            end else if (scl_fall) begin
              if (mack && byte_idx < IW'(BYTES)) begin
                byte_idx <= byte_idx + 1'b1;
                st <= ST_TX; bitcnt <= '0; oe_q <= ~shreg[7];
              end else begin
                st <= ST_SKIP; oe_q <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  sda_drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_s);
  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !oe_q);
  // R4
  busy_cmd_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_dec && busy_i) |=> !oe_q);
  // R6
  rd_legal_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> ptr_ok);
endmodule

// File: tb/sim_smb_blkrd_slave.sv
module sim_smb_blkrd_slave;
  localparam int Q = 8;
  localparam logic [6:0] SA = 7'h52;

  logic clk = 1'b0, rst_n = 1'b0, busy = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, mem_rd_en;
  logic [7:0] mem_rd_addr, mem_rd_data;
  wire sda_w = sda_m & ~sda_oe;

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got_v;
  string got_req;
  event byte_ev;
  logic [7:0] ptr_m = 8'hFF;

  always #10 clk = ~clk;

  smb_blkrd_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_w), .sda_oe(sda_oe),
    .busy_i(busy), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data)
  );

  always_ff @(posedge clk) mem_rd_data <= mem_rd_en ? mem_rd_addr + 8'h80 : 8'h00;

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always begin
    @(byte_ev);
    if (exp_q.size() == 0) chk(1'b0, got_req, got_v, 0);
    else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      chk(got_v == e, got_req, got_v, e);
    end
  end

  function automatic logic [7:0] adv(input logic [7:0] p);
    return (p == 8'h2F || p == 8'h9F) ? p : p + 8'h1;
  endfunction

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_bit(input logic b, output logic smp);
    sda_m = b; wq(); scl_m = 1'b1; wq(); smp = sda_w; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic d;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], d);
    bus_bit(1'b1, d);
    ack = ~d;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] v);
    logic d;
    for (int i = 7; i >= 0; i--) bus_bit(1'b1, v[i]);
    bus_bit(~mack, d);
    sda_m = 1'b1;
  endtask

  task automatic rd_emit(input logic mack, input string req);
    logic [7:0] v;
    rd_byte(mack, v);
    got_v = v; got_req = req; ->byte_ev; #1;
  endtask

  task automatic set_ptr(input logic [7:0] a, input logic exp_ack);
    logic ack;
    bus_start();
    wr_byte({SA, 1'b0}, ack); chk(ack, "R2 addr ack", ack, 1);
    wr_byte(a, ack);          chk(ack == exp_ack, "R3 preset ack", ack, exp_ack);
    bus_stop();
    if (exp_ack) ptr_m = a;
  endtask

  // reads count plus n data bytes; last one NACKed if nack_last; no STOP
  task automatic blk_read(input int n, input logic nack_last);
    logic ack;
    bus_start();
    wr_byte({SA, 1'b0}, ack); chk(ack, "R2 addr ack", ack, 1);
    wr_byte(8'hC1, ack);      chk(ack, "R4 cmd ack", ack, 1);
    bus_start();
    wr_byte({SA, 1'b1}, ack); chk(ack, "R5 read addr ack", ack, 1);
    exp_q.push_back(8'h10);
    rd_emit(1'b1, "R5 count");
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(ptr_m + 8'h80);
      ptr_m = adv(ptr_m);
      rd_emit(!(nack_last && k == n - 1), "R6 R7 R10 data");
    end
    if (nack_last) begin
      repeat (4) @(negedge clk);
      chk(sda_oe == 1'b0, "R8 release after nack", sda_oe, 0);
    end
  endtask

  initial begin
    logic ack;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk(sda_oe == 1'b0, "R11 sda released", sda_oe, 0);
    chk(mem_rd_en == 1'b0, "R11 no read", mem_rd_en, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // C1 with reset pointer (illegal)
    bus_start();
    wr_byte({SA, 1'b0}, ack); chk(ack, "R2 addr ack", ack, 1);
    wr_byte(8'hC1, ack);      chk(!ack, "R4 nack illegal ptr", ack, 0);
    bus_stop();
    // read address with no armed command
    bus_start();
    wr_byte({SA, 1'b1}, ack); chk(!ack, "R9 unarmed read nack", ack, 0);
    bus_stop();

    // full block into the 2Fh ceiling, then a 17th byte
    set_ptr(8'h28, 1'b1);
    blk_read(16, 1'b0);
    rd_byte(1'b0, v);
    chk(v == 8'hFF, "R6 released after 16", v, 8'hFF);
    bus_stop();

    // rejected preset leaves pointer at 2Fh
    set_ptr(8'h30, 1'b0);
    blk_read(2, 1'b1); bus_stop();

    // address mismatch: everything ignored
    bus_start();
    wr_byte({7'h13, 1'b0}, ack); chk(!ack, "R2 mismatch nack", ack, 0);
    wr_byte(8'h40, ack);         chk(!ack, "R2 ignored byte", ack, 0);
    bus_stop();
    blk_read(1, 1'b1); bus_stop();

    // busy refusals
    set_ptr(8'h7C, 1'b1);
    busy = 1'b1;
    bus_start();
    wr_byte({SA, 1'b0}, ack); chk(ack, "R2 addr ack", ack, 1);
    wr_byte(8'hC1, ack);      chk(!ack, "R4 busy nack", ack, 0);
    bus_stop();
    set_ptr(8'h10, 1'b0);
    busy = 1'b0;

    // crossing 7Fh -> 80h, then continue from 82h
    blk_read(6, 1'b1); bus_stop();
    blk_read(1, 1'b1); bus_stop();

    // early STOP after two acknowledged data bytes
    set_ptr(8'h50, 1'b1);
    blk_read(2, 1'b0);
    bus_stop();
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R8 R1 release after stop", sda_oe, 0);
    blk_read(1, 1'b1); bus_stop();

    // 9Fh ceiling
    set_ptr(8'h9E, 1'b1);
    blk_read(3, 1'b1); bus_stop();

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule